// File: doc/BRIEF.md
# Bit-Serial Carry-Save Multiplier

This block multiplies two unsigned N-bit numbers. It produces the 2N-bit product one bit per clock, least significant bit first. A single start strobe captures both operands. The multiplicand is held in a parallel register. The multiplier goes into a right-shifting register that presents one bit per clock and shifts in zeros once its own bits are used up.

The datapath has one full adder per multiplicand bit. Each adder adds three things:
- the AND of its multiplicand bit with the current multiplier bit,
- the registered sum of its higher-order neighbour,
- its own registered carry from the previous clock.

Carries are saved locally and never travel across the word. After N clocks the multiplier bits are exhausted. N further clocks with a zero multiplier bit then drain the saved sums and carries. A one-cycle flag marks the last product bit.

Top module: `sp_csa_mul`

## Requirements
- R1: A start strobe sampled high loads `mcand` and `mplier` and clears every saved sum and carry. In the following cycle `prod_valid` and `done` are low.
- R2: After a start sampled at edge E0, `prod_valid` is high in the 2N consecutive cycles that follow edges E1 to E2N, and low otherwise, unless another start intervenes.
- R3: In the k-th valid cycle (k counted from 0), `prod_bit` equals bit k of `mcand × mplier`. For 14 × 11 the collected value is 154. Multiplier bits are consumed from bit 0 upward, and zeros are used after bit N-1.
- R4: `done` is high for exactly one cycle, together with the last valid product bit (bit 2N-1).
- R5: Changes to `mcand` or `mplier` while no start is sampled have no effect on the product being delivered.
- R6: A start sampled while a product is still being delivered abandons it. The new operands' product then follows with the timing of R2.
- R7: After the 2N-th step all saved carries and all saved sums except the output bit are zero. All-ones operands therefore deliver the full product 2^(2N) − 2^(N+1) + 1.
- R8: While reset is asserted, and until the first start after it, `prod_valid` and `done` are low. Reset is asserted asynchronously, active low, and released synchronously over two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin a product |
| mcand | input | N | Multiplicand, captured in parallel on start |
| mplier | input | N | Multiplier, captured on start and consumed serially |
| prod_bit | output | 1 | Current product bit, LSB first |
| prod_valid | output | 1 | `prod_bit` carries a product bit |
| done | output | 1 | Last product bit is being presented |

## Verification
A corrupted saved carry or sum shows up at `prod_bit` in the same cycle as the bit of its own weight. That bit leaves the block at most N cycles after the fault, so comparing every clock against a behavioural reference catches it within one product. A fault in the multiplier shift or in the step counter instead misplaces the `prod_valid` window or the `done` pulse, which the per-cycle comparison flags on the first wrong cycle. Operands that are all ones exercise the longest chain of saved carries, which drains only in the last flush cycles.

// File: rtl/sp_csa_mul_pkg.sv
package sp_csa_mul_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sp_csa_mul_ctrl.sv
module sp_csa_mul_ctrl
  import sp_csa_mul_pkg::*;
#(
  parameter int N  = 8,
  localparam int CW = $clog2(2 * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          last_step,
  output logic [CW-1:0] step_idx
);
  localparam logic [CW-1:0] LAST = CW'(2 * N - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start) begin
      state_d = SEQ_RUN;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (state_q == SEQ_RUN) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy      = (state_q == SEQ_RUN);
  assign last_step = busy && (cnt_q == LAST);
  assign step_idx  = cnt_q;

  // R2: a run stays busy until its last step unless restarted
  p_run_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step && !start) |=> busy);
endmodule

// File: rtl/sp_csa_mul_shreg.sv
module sp_csa_mul_shreg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] din,
  output logic         bit_out
);
  logic [N-1:0] q_q, q_d;
  logic         q_en;

  always_comb begin
    q_en = load | shift;
    if (load) q_d = din;
    else      q_d = {1'b0, q_q[N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign bit_out = q_q[0];

  // R3: the top slot refills with zeros while shifting
  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> !q_q[N-1]);
endmodule

// File: rtl/sp_csa_mul_cell.sv
module sp_csa_mul_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic pp,
  input  logic sum_in,
  output logic sum_q,
  output logic carry_q
);
  logic sum_d, carry_d;

  always_comb begin
    sum_d   = pp ^ sum_in ^ carry_q;
    carry_d = (pp & sum_in) | (pp & carry_q) | (sum_in & carry_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (clr) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (en) begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  // R1: a clear leaves the cell empty
  p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!sum_q && !carry_q));
endmodule

// File: rtl/sp_csa_mul.sv
module sp_csa_mul #(
  parameter int N  = 8,
  localparam int CW = $clog2(2 * N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic         prod_bit,
  output logic         prod_valid,
  output logic         done
);
  logic [1:0]    rsync_q;
  logic          rst_s_n;
  logic [N-1:0]  a_q;
  logic [N-1:0]  s_q, c_q;
  logic          busy, last_step, mbit, step_en;
  logic [CW-1:0] step_idx;
  logic          valid_d, done_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   a_q <= '0;
    else if (start) a_q <= mcand;
  end

  sp_csa_mul_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .busy      (busy),
    .last_step (last_step),
    .step_idx  (step_idx)
  );

  assign step_en = busy && !start;

  sp_csa_mul_shreg #(.N(N)) u_mreg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (start),
    .shift   (step_en),
    .din     (mplier),
    .bit_out (mbit)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic sin;
    if (i == N - 1) begin : g_top
      assign sin = 1'b0;
    end else begin : g_mid
      assign sin = s_q[i+1];
    end
    sp_csa_mul_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .clr     (start),
      .en      (step_en),
      .pp      (a_q[i] & mbit),
      .sum_in  (sin),
      .sum_q   (s_q[i]),
      .carry_q (c_q[i])
    );
  end

  always_comb begin
    valid_d = step_en;
    done_d  = step_en && last_step;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      prod_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      prod_valid <= valid_d;
      done       <= done_d;
    end
  end

  assign prod_bit = s_q[0];

  p_start_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    start |=> (!prod_valid && !done));
  p_valid_contig_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (prod_valid && !done && !start) |=> prod_valid);
  p_zero_tail_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && step_idx >= CW'(N)) |-> !mbit);
  p_done_with_bit_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> prod_valid);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);
  p_mcand_held_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !start) |=> $stable(a_q));
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (c_q == '0 && s_q[N-1:1] == '0));
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_s_n |-> (!prod_valid && !done));
endmodule

// File: tb/sp_csa_mul_bench.sv
module sp_csa_mul_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [N-1:0] mcand, mplier;
  logic         prod_bit, prod_valid, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  sp_csa_mul #(.N(N)) u_sp_csa_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .prod_bit(prod_bit), .prod_valid(prod_valid),
    .done(done)
  );

  // behavioural reference: product known at start, bits handed out in order
  logic [2*N-1:0] m_prod;
  int             m_cnt;
  bit             m_run, m_valid, m_done, m_bit;

  always @(posedge clk) begin
    if (!rst_n || !cmp_on) begin
      m_run <= 0; m_valid <= 0; m_done <= 0; m_bit <= 0; m_cnt <= 0;
    end else if (start) begin
      m_prod  <= (2*N)'(mcand) * (2*N)'(mplier);
      m_cnt   <= 0;
      m_run   <= 1;
      m_valid <= 0;
      m_done  <= 0;
    end else if (m_run) begin
      m_valid <= 1;
      m_bit   <= m_prod[m_cnt];
      m_done  <= (m_cnt == 2*N-1);
      m_cnt   <= m_cnt + 1;
      if (m_cnt == 2*N-1) m_run <= 0;
    end else begin
      m_valid <= 0;
      m_done  <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(prod_valid == m_valid, "R2 prod_valid", prod_valid, m_valid);
      chk(done == m_done, "R4 done", done, m_done);
      if (m_valid) chk(prod_bit == m_bit, "R3 prod_bit", prod_bit, m_bit);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // run one product; optionally scramble inputs mid-run (R5)
  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b,
                     input bit scramble, input string tag);
    logic [2*N-1:0] got;
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin mcand = ~a; mplier = ~b; end
    for (int k = 0; k < 2*N; k++) begin
      @(negedge clk);
      got[k] = prod_bit;
      if (scramble && k == 3) begin mcand = a ^ 8'h5a; mplier = b + 1; end
    end
    chk(got == (2*N)'(a) * (2*N)'(b), tag, got, (2*N)'(a) * (2*N)'(b));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mcand = '0; mplier = '0;
    repeat (3) @(negedge clk);
    chk(!prod_valid && !done, "R8 reset quiet", {prod_valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!prod_valid && !done, "R8 after release", {prod_valid, done}, 0);
    cmp_on = 1'b1;

    run(8'd14, 8'd11, 0, "R3 14x11=154");
    run(8'hff, 8'hff, 0, "R7 all ones flush");
    run(8'd0, 8'd37, 0, "R1 cleared state zero product");
    run(8'd200, 8'd133, 1, "R5 inputs ignored mid-run");

    // R6: restart in the middle of a product
    @(negedge clk);
    start = 1'b1; mcand = 8'd99; mplier = 8'd201;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    run(8'd173, 8'd58, 0, "R6 restart product");

    // exhaustive 4-bit operands, back to back
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run(N'(a), N'(b), 0, "R3 exhaustive 4-bit");

    // random full-width operands
    for (int i = 0; i < 300; i++)
      run(N'($urandom), N'($urandom), (i % 7) == 0, "R3 random 8-bit");

    repeat (4) @(negedge clk);
    chk(!prod_valid && !done, "R2 idle after run", {prod_valid, done}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule